// File: doc/BRIEF.md
# LCD Frame Sync Timing Generator

This block produces the line and frame synchronization strobes that a panel controller needs. A pixel-clock enable input sets the pace. A programmable line length counts pixel periods into one horizontal period. A programmable frame length counts horizontal periods into one vertical period. The frame rate is therefore the pixel rate divided by (line_len + 1) × (frame_len + 1). Software must set the frame length to at least the panel's common lines plus its dummy lines.

The vertical pulse lasts one, two or three whole lines, and its polarity can be inverted. Four edge-select bits go straight to the strobe drivers outside the block. These bits choose the active edge of the pixel clock, the line strobe, the vertical strobe and the load strobe. A one-clock frame_start pulse marks the beginning of each vertical period for the fetch logic downstream.

All settings are written through a byte-wide write port. Changes to line length, frame length and pulse width are held back until the next frame boundary, so a frame in progress always keeps its geometry.

Top module: `lcd_sync_gen`

## Requirements
- R1: Each line lasts line_len + 1 pixel periods, where a pixel period ends on a clock with pix_en high. hsync is high for exactly the first pixel period of each line.
- R2: Each frame lasts frame_len + 1 lines. vsync is active starting with line 0 of every frame.
- R3: The write map is as follows. Address 0 holds line_len[7:0] and address 1 holds line_len[15:8]. Address 2 holds frame_len[7:0], and address 3 holds frame_len[9:8] in data bits 1:0. Both lengths reset to 0, so an enable with the reset lengths gives a one-pixel line and a one-line frame.
- R4: Control register (address 4) bits 3:2 select the vertical pulse width: 00 gives 1 line, 01 gives 2 lines and 10 gives 3 lines.
- R5: Width code 11 behaves exactly like 00, giving a 1-line pulse.
- R6: Control bit 1 sets the vsync polarity and resets to 1. When it is 1, vsync is high while active and low while idle. When it is 0, vsync is low while active and high while idle.
- R7: Control bit 0 enables the block and resets to 0. While it is 0, hsync and frame_start are 0, vsync sits at its inactive level, and both counters are held at zero. Setting it starts a new frame at line 0, pixel 0, on the second clock edge after the write.
- R8: Address 5 bits 0, 1, 2 and 3 drive pclk_fall, hsync_fall, vsync_fall and load_fall, where 1 selects the falling edge. All four bits reset to 0, and a write shows on the outputs from the clock after it.
- R9: Position advances only on clocks with pix_en high. frame_start is high for one clock at the start of each frame, together with hsync.
- R10: Values written for line_len, frame_len or pulse width while the block is running take effect at the next frame boundary. The frame in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable, one pixel period ends per high clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| hsync | output | 1 | Line sync, high for the first pixel period of a line |
| vsync | output | 1 | Frame sync, polarity set by control bit 1 |
| frame_start | output | 1 | One-clock pulse at the start of each frame |
| pclk_fall | output | 1 | Pixel-clock active-edge select |
| hsync_fall | output | 1 | Line-strobe active-edge select |
| vsync_fall | output | 1 | Vertical-strobe active-edge select |
| load_fall | output | 1 | Load-strobe active-edge select |

## Verification
The bench goes after several corner cases:

- Reset lengths of zero: every clock is then a line start and a frame start. A counter that compares before wrapping would give two-pixel lines instead.
- Each of the four width codes: a design that decoded the reserved code literally would hold vsync for four lines, or for none.
- The 10-bit frame length spanning two bytes: a wrong split of the high byte would give a frame of the wrong length.
- A pixel enable that is high only every third clock: an output that was not held between enables would shorten hsync, or repeat frame_start.
- A line-length write in the middle of a frame: a design without staging would cut the running frame short.
- Disabling, then enabling again: a design that did not clear its counters would resume in the middle of a line.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  localparam int unsigned DATA_W      = 8;
  localparam int unsigned NUM_PHASE   = 4;
  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_POL    = 1;
  localparam int unsigned CTRL_WLO    = 2;

  // Decoded width of the vertical pulse in lines; the spare code maps to one.
  function automatic logic [1:0] vs_lines(input logic [1:0] code);
    logic [1:0] n;
    case (code)
      2'b01:   n = 2'd2;
      2'b10:   n = 2'd3;
      default: n = 2'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lcd_sync_regs.sv
module lcd_sync_regs
  import lcd_sync_pkg::*;
#(
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 10,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [LINE_W-1:0]     line_len,
  output logic [FRAME_W-1:0]    frame_len,
  output logic                  enable,
  output logic                  vs_pol,
  output logic [1:0]            vs_wcode,
  output logic [NUM_PHASE-1:0]  phase
);

  localparam int unsigned LB     = (LINE_W + DATA_W - 1) / DATA_W;
  localparam int unsigned FB     = (FRAME_W + DATA_W - 1) / DATA_W;
  localparam int unsigned CTRL_A = LB + FB;
  localparam int unsigned PH_A   = CTRL_A + 1;

  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;

  // One byte lane per slice of each length field; the top lane keeps only its live bits.
  generate
    for (genvar i = 0; i < LB; i++) begin : g_line
      localparam int unsigned LO = i * DATA_W;
      localparam int unsigned NB = (LINE_W - LO > DATA_W) ? DATA_W : LINE_W - LO;
      always_ff @(posedge clk) begin
        if (rst)                                line_q[LO +: NB] <= '0;
        else if (we && addr == ADDR_W'(i))      line_q[LO +: NB] <= wdata[NB-1:0];
      end
    end
    for (genvar j = 0; j < FB; j++) begin : g_frame
      localparam int unsigned LO = j * DATA_W;
      localparam int unsigned NB = (FRAME_W - LO > DATA_W) ? DATA_W : FRAME_W - LO;
      always_ff @(posedge clk) begin
        if (rst)                                frame_q[LO +: NB] <= '0;
        else if (we && addr == ADDR_W'(LB + j)) frame_q[LO +: NB] <= wdata[NB-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      vs_pol   <= 1'b1;
      vs_wcode <= 2'b00;
      phase    <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(CTRL_A)) begin
        enable   <= wdata[CTRL_EN];
        vs_pol   <= wdata[CTRL_POL];
        vs_wcode <= wdata[CTRL_WLO +: 2];
      end
      if (addr == ADDR_W'(PH_A)) phase <= wdata[NUM_PHASE-1:0];
    end
  end

  assign line_len  = line_q;
  assign frame_len = frame_q;

endmodule

// File: rtl/lcd_sync_cnt.sv
module lcd_sync_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_lim
);

  assign at_lim = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= at_lim ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/lcd_sync_core.sv
module lcd_sync_core
  import lcd_sync_pkg::*;
#(
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic               enable,
  input  logic               vs_pol,
  input  logic [LINE_W-1:0]  line_len,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic [1:0]         vs_wcode,
  output logic               hsync,
  output logic               vsync,
  output logic               frame_start,
  output logic               running,
  output logic [LINE_W-1:0]  h_pos,
  output logic [LINE_W-1:0]  h_limit
);

  localparam int unsigned VW = FRAME_W + 1;

  logic [LINE_W-1:0]  line_sh;
  logic [FRAME_W-1:0] frame_sh;
  logic [1:0]         wcode_sh;
  logic [FRAME_W-1:0] v_pos;
  logic               h_at, v_at;
  logic               step_h, step_v, frame_wrap, load_sh;
  logic               vs_act, act_nxt;
  logic [VW-1:0]      v_inc, lines_n;

  assign step_h     = enable & running & pix_en;
  assign step_v     = step_h & h_at;
  assign frame_wrap = step_v & v_at;
  assign load_sh    = (enable & ~running) | frame_wrap;

  // Geometry is staged and only refreshed when a frame begins.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_sh  <= '0;
      frame_sh <= '0;
      wcode_sh <= 2'b00;
    end else if (load_sh) begin
      line_sh  <= line_len;
      frame_sh <= frame_len;
      wcode_sh <= vs_wcode;
    end
  end

  lcd_sync_cnt #(.W(LINE_W)) h_cnt_i (
    .clk(clk), .rst(rst), .clr(~enable), .step(step_h),
    .limit(line_sh), .cnt(h_pos), .at_lim(h_at)
  );

  lcd_sync_cnt #(.W(FRAME_W)) v_cnt_i (
    .clk(clk), .rst(rst), .clr(~enable), .step(step_v),
    .limit(frame_sh), .cnt(v_pos), .at_lim(v_at)
  );

  assign lines_n = {{(VW-2){1'b0}}, vs_lines(wcode_sh)};
  assign v_inc   = {1'b0, v_pos} + 1'b1;
  assign act_nxt = v_at ? 1'b1 : (v_inc < lines_n);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running     <= 1'b0;
      hsync       <= 1'b0;
      vs_act      <= 1'b0;
      frame_start <= 1'b0;
    end else if (!running) begin
      running     <= 1'b1;
      hsync       <= 1'b1;
      vs_act      <= 1'b1;
      frame_start <= 1'b1;
    end else if (pix_en) begin
      hsync       <= h_at;
      frame_start <= h_at & v_at;
      if (h_at) vs_act <= act_nxt;
    end else begin
      frame_start <= 1'b0;
    end
  end

  assign vsync   = vs_pol ? vs_act : ~vs_act;
  assign h_limit = line_sh;

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 10,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic              hsync,
  output logic              vsync,
  output logic              frame_start,
  output logic              pclk_fall,
  output logic              hsync_fall,
  output logic              vsync_fall,
  output logic              load_fall
);

  logic [LINE_W-1:0]    line_len;
  logic [FRAME_W-1:0]   frame_len;
  logic                 cfg_enable, cfg_pol;
  logic [1:0]           cfg_wcode;
  logic [NUM_PHASE-1:0] cfg_phase;
  logic                 core_running;
  logic [LINE_W-1:0]    core_hpos, core_hlim;

  lcd_sync_regs #(.LINE_W(LINE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .line_len(line_len), .frame_len(frame_len), .enable(cfg_enable),
    .vs_pol(cfg_pol), .vs_wcode(cfg_wcode), .phase(cfg_phase)
  );

  lcd_sync_core #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) core_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .enable(cfg_enable), .vs_pol(cfg_pol),
    .line_len(line_len), .frame_len(frame_len), .vs_wcode(cfg_wcode),
    .hsync(hsync), .vsync(vsync), .frame_start(frame_start),
    .running(core_running), .h_pos(core_hpos), .h_limit(core_hlim)
  );

  assign pclk_fall  = cfg_phase[0];
  assign hsync_fall = cfg_phase[1];
  assign vsync_fall = cfg_phase[2];
  assign load_fall  = cfg_phase[3];

endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk #(
  parameter int unsigned LINE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_en,
  input logic              enable,
  input logic              running,
  input logic              vs_pol,
  input logic              hsync,
  input logic              vsync,
  input logic              frame_start,
  input logic [LINE_W-1:0] h_pos,
  input logic [LINE_W-1:0] h_limit
);

  AST_FS_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> hsync);                                          // R9

  AST_FS_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !pix_en) |=> !frame_start);                      // R9

  AST_HS_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (running && enable && !pix_en) |=> $stable(hsync));              // R1

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (!hsync && !frame_start && (vsync == !vs_pol))); // R7

  AST_HPOS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (h_pos <= h_limit));                                 // R1

endmodule

bind lcd_sync_gen lcd_sync_chk #(.LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst(rst), .pix_en(pix_en), .enable(cfg_enable),
  .running(core_running), .vs_pol(cfg_pol), .hsync(hsync), .vsync(vsync),
  .frame_start(frame_start), .h_pos(core_hpos), .h_limit(core_hlim)
);

// File: tb/lcd_sync_gen_tb_top.sv
module lcd_sync_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_LLO = 3'd0, A_FLO = 3'd2, A_FHI = 3'd3,
                         A_CTRL = 3'd4, A_PH = 3'd5;

  logic       clk = 1'b0, rst = 1'b1, pix_en = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       hsync, vsync, frame_start, pclk_fall, hsync_fall, vsync_fall, load_fall;

  int nvec = 0, nbad = 0;

  typedef struct {
    logic  hs;
    logic  vs;
    logic  fs;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_sync_gen dut_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .frame_start(frame_start),
    .pclk_fall(pclk_fall), .hsync_fall(hsync_fall), .vsync_fall(vsync_fall),
    .load_fall(load_fall)
  );

  task automatic check3(string tag, logic ah, logic av, logic af, logic eh, logic ev, logic ef);
    nvec++;
    if ({ah, av, af} !== {eh, ev, ef}) begin
      nbad++;
      $display("FAIL %s: hs/vs/fs actual %b%b%b expected %b%b%b", tag, ah, av, af, eh, ev, ef);
    end
  endtask

  // Monitor: pops one expected item per clock while the scoreboard holds any.
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check3(e.tag, hsync, vsync, frame_start, e.hs, e.vs, e.fs);
    end
  end

  function automatic int wlines(int code);
    return (code == 1) ? 2 : (code == 2) ? 3 : 1;
  endfunction

  // Driver side: expected clocks of one frame, from the line/frame/width rules.
  task automatic push_frame(int l, int f, int w, bit pol, int d, string tag);
    exp_t e;
    for (int v = 0; v <= f; v++)
      for (int h = 0; h <= l; h++)
        for (int k = 0; k < d; k++) begin
          e.hs  = (h == 0);
          e.vs  = pol ? (v < wlines(w)) : !(v < wlines(w));
          e.fs  = (h == 0) && (v == 0) && (k == 0);
          e.tag = tag;
          sb.push_back(e);
        end
  endtask

  task automatic cfg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Runs n clocks with pix_en high once every d clocks; optional write at clock wk.
  task automatic run_window(int n, int d, int wk, logic [2:0] wa, logic [7:0] wd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      pix_en = ((k % d) == d - 1);
      if (k == wk) begin
        cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk); #1;
    cfg_we = 1'b0; pix_en = 1'b0;
  endtask

  task automatic stop_and_idle(bit pol, string tag);
    cfg_write(A_CTRL, {6'd0, pol, 1'b0});
    pix_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check3(tag, hsync, vsync, frame_start, 1'b0, !pol, 1'b0);
    end
    pix_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // Reset state: idle strobes with polarity 1, edge selects at 0 (R6, R8)
    check3("R6 reset", hsync, vsync, frame_start, 1'b0, 1'b0, 1'b0);
    nvec++;
    if ({load_fall, vsync_fall, hsync_fall, pclk_fall} !== 4'b0000) begin
      nbad++;
      $display("FAIL R8 reset phase actual %b expected 0000",
               {load_fall, vsync_fall, hsync_fall, pclk_fall});
    end

    // R3: reset lengths of zero give a frame start on every pixel
    cfg_write(A_CTRL, 8'h03);
    for (int i = 0; i < 4; i++) push_frame(0, 0, 0, 1, 1, "R3 zero lengths");
    run_window(4, 1, -1, 3'd0, 8'd0);
    stop_and_idle(1, "R7 idle pol1");

    // R1 R2 R7: line of 4 pixels, frame of 3 lines, restart from zero
    cfg_write(A_LLO, 8'd3);
    cfg_write(A_FLO, 8'd2);
    cfg_write(A_CTRL, 8'h03);
    push_frame(3, 2, 0, 1, 1, "R1 R2 R7 restart");
    push_frame(3, 2, 0, 1, 1, "R1 R2");
    run_window(24, 1, -1, 3'd0, 8'd0);
    stop_and_idle(1, "R7 idle again");

    // R4 R5: pulse width codes
    cfg_write(A_LLO, 8'd1);
    cfg_write(A_FLO, 8'd4);
    for (int w = 1; w <= 3; w++) begin
      cfg_write(A_CTRL, 8'(w * 4 + 3));
      push_frame(1, 4, w, 1, 1, (w == 3) ? "R5 reserved width" : "R4 width");
      push_frame(1, 4, w, 1, 1, (w == 3) ? "R5 reserved width" : "R4 width");
      run_window(20, 1, -1, 3'd0, 8'd0);
      stop_and_idle(1, "R7 idle width");
    end

    // R6: inverted polarity, idle and active
    cfg_write(A_CTRL, 8'h00);
    stop_and_idle(0, "R6 idle pol0");
    cfg_write(A_CTRL, 8'h05);
    push_frame(1, 4, 1, 0, 1, "R6 pol0");
    run_window(10, 1, -1, 3'd0, 8'd0);
    stop_and_idle(1, "R7 idle pol restore");

    // R9: pixel enable every third clock
    cfg_write(A_LLO, 8'd2);
    cfg_write(A_FLO, 8'd1);
    cfg_write(A_CTRL, 8'h03);
    push_frame(2, 1, 0, 1, 3, "R9 slow pixel");
    push_frame(2, 1, 0, 1, 3, "R9 slow pixel");
    run_window(36, 3, -1, 3'd0, 8'd0);
    stop_and_idle(1, "R7 idle slow");

    // R3: frame length high byte, 257-line frame, 3-line pulse
    cfg_write(A_LLO, 8'd0);
    cfg_write(A_FLO, 8'd0);
    cfg_write(A_FHI, 8'd1);
    cfg_write(A_CTRL, 8'h0B);
    push_frame(0, 256, 2, 1, 1, "R3 frame high byte");
    push_frame(0, 0, 2, 1, 1, "R3 frame high byte wrap");
    run_window(258, 1, -1, 3'd0, 8'd0);
    stop_and_idle(1, "R7 idle long");
    cfg_write(A_FHI, 8'd0);

    // R10: line length written mid-frame applies from the next frame
    cfg_write(A_LLO, 8'd3);
    cfg_write(A_FLO, 8'd1);
    cfg_write(A_CTRL, 8'h03);
    push_frame(3, 1, 0, 1, 1, "R10 old geometry");
    push_frame(1, 1, 0, 1, 1, "R10 new geometry");
    push_frame(1, 1, 0, 1, 1, "R10 new geometry");
    run_window(16, 1, 2, A_LLO, 8'd1);
    stop_and_idle(1, "R7 idle shadow");

    // R8: edge select bits
    cfg_write(A_PH, 8'h0A);
    nvec++;
    if ({load_fall, vsync_fall, hsync_fall, pclk_fall} !== 4'b1010) begin
      nbad++;
      $display("FAIL R8 phase actual %b expected 1010",
               {load_fall, vsync_fall, hsync_fall, pclk_fall});
    end

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      nbad++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule